// File: doc/BRIEF.md
# Program-Window Bank Mapper

This block turns a CPU address in the upper part of a 16-bit space into a physical program-ROM bank number, or into a request for work RAM. Software programs four 8-bit bank registers and a small mode register through a plain write strobe. It then chooses between one 32 KiB window, two 16 KiB windows, four 8 KiB windows, or four 8 KiB windows whose bank numbers are bit-reversed. The top window can either track bank register 3 or stay pinned to the highest bank. The 8 KiB window at 0x6000 can show a ROM bank, whose number is derived from register 3 according to the size mode, or it can select work RAM.

Two external inputs, an AND mask and an OR offset, confine the result to an outer slice of a larger ROM so that one cartridge can hold several games. The lookup is combinational. The registers change only on a clock edge, and an address presented on `cpu_addr` returns its bank, its window size and its ROM/RAM select in the same cycle. Whether work RAM exists is fixed by the parameter `RAM_PRESENT`.

The mapping has no sequencing of its own. The only states are the register contents, and the four size modes act as the states of the lookup: WIDE (one 32 KiB window), HALF (two 16 KiB windows), QUARTER (four 8 KiB windows) and QUARTER_REV (four 8 KiB windows, reversed). The only transition is a write to the mode register, which moves the mapper from its current size mode to the one that was written.

Top module: `prg_map`

## Requirements
- R1: After reset all four bank registers and every mode field are zero. The mapper is in WIDE mode with a pinned top bank and shows RAM (or nothing) at 0x6000.
- R2: A write with `wr_addr` in 0x8000–0x87FF loads bank register `wr_addr[1:0]` with `wr_data`. Writes in 0x8800–0x8FFF, and writes anywhere else, leave the bank registers unchanged.
- R3: A write to 0xD000–0xD7FF with `wr_addr[1:0]`=0 loads the mode fields: `wr_data[1:0]` is the size mode (0 WIDE, 1 HALF, 2 QUARTER, 3 QUARTER_REV), `wr_data[2]` makes the top bank programmable, and `wr_data[7]` puts ROM at 0x6000. Any other write, including one to 0xD001 or 0xD800, leaves the mode unchanged.
- R4: In WIDE mode, every address in 0x8000–0xFFFF returns the top value ANDed with mask>>2 and ORed with offset>>2, with `win_size`=0 (32 KiB units).
- R5: In HALF mode, 0x8000–0xBFFF returns register 1 and 0xC000–0xFFFF returns the top value. Both are masked with mask>>1 and offset>>1, and `win_size`=1.
- R6: In QUARTER mode, the four 8 KiB windows from 0x8000 upward return registers 0, 1 and 2 and then the top value, each ANDed with the mask and ORed with the offset, with `win_size`=2.
- R7: In QUARTER_REV mode, each 8 KiB bank value has bit 0 swapped with bit 6, bit 1 with bit 5 and bit 2 with bit 4. Bit 3 is kept and bit 7 becomes 0. This happens before the mask and offset are applied, and `win_size`=2.
- R8: The top value is register 3 when the programmable-top bit is set, and 0xFF otherwise.
- R9: With ROM enabled at 0x6000, the 8 KiB bank there is computed from register 3 and truncated to 8 bits before the mask and offset are applied. In WIDE mode it is reg3<<2 with the two low bits set. In HALF mode it is reg3<<1 with bit 0 set. In QUARTER mode it is reg3, and in QUARTER_REV mode it is reg3 reversed.
- R10: With the ROM bit clear, 0x6000–0x7FFF asserts `ram_sel` only when `RAM_PRESENT` is 1. `rom_sel` is never asserted together with `ram_sel`.
- R11: Every ROM bank returned at 0x6000, or in the 8 KiB modes, equals (value AND `and_mask`) OR `or_offset` at full `BANK_W` width.
- R12: Addresses below 0x6000 assert neither select and return bank 0. The lookup reflects `cpu_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| and_mask | input | BANK_W | Outer bank AND mask |
| or_offset | input | BANK_W | Outer bank OR offset |
| cpu_addr | input | 16 | Address to translate |
| rom_bank | output | BANK_W | Physical bank in units of `win_size` |
| win_size | output | 2 | 0: 32 KiB, 1: 16 KiB, 2: 8 KiB |
| rom_sel | output | 1 | Address maps to program ROM |
| ram_sel | output | 1 | Address maps to work RAM |

## Verification
A register write takes effect at the clock edge that samples it. The outputs follow that edge only through combinational logic, so the bench drives each write around the falling edge and checks the result after the next falling edge, one edge later. Address lookups involve no register, so each check changes `cpu_addr`, waits one time unit and compares in the same cycle, well before the next rising edge. A second instance built without work RAM shares every input, so both RAM options can be compared against the same register contents.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_IW   = $clog2(NUM_SLOTS);

    typedef enum logic [1:0] {
        MODE_WIDE        = 2'd0,
        MODE_HALF        = 2'd1,
        MODE_QUARTER     = 2'd2,
        MODE_QUARTER_REV = 2'd3
    } size_mode_e;

    // Units of the returned bank number
    localparam logic [1:0] WSZ_32K = 2'd0;
    localparam logic [1:0] WSZ_16K = 2'd1;
    localparam logic [1:0] WSZ_8K  = 2'd2;

    // Mirror bits 0..6 about bit 3, drop bit 7
    function automatic logic [REG_W-1:0] mirror7(input logic [REG_W-1:0] v);
        return {1'b0, v[0], v[1], v[2], v[3], v[4], v[5], v[6]};
    endfunction

endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
    import prg_map_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [15:0]                       wr_addr,
    input  logic [REG_W-1:0]                  wr_data,
    output logic [NUM_SLOTS-1:0][REG_W-1:0]   bank_q,
    output size_mode_e                        size_q,
    output logic                              top_prog_q,
    output logic                              low_rom_q
);

    logic bank_hit;
    logic mode_hit;

    assign bank_hit = wr_en && (wr_addr[15:11] == 5'b10000);
    assign mode_hit = wr_en && (wr_addr[15:11] == 5'b11010) && (wr_addr[1:0] == 2'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (bank_hit) begin
            bank_q[wr_addr[SLOT_IW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q     <= MODE_WIDE;
            top_prog_q <= 1'b0;
            low_rom_q  <= 1'b0;
        end else if (mode_hit) begin
            size_q     <= size_mode_e'(wr_data[1:0]);
            top_prog_q <= wr_data[2];
            low_rom_q  <= wr_data[7];
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr[15:11] != 5'b10000) |=> $stable(bank_q)); // R2

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:11] == 5'b10000) |=>
            bank_q[$past(wr_addr[1:0])] == $past(wr_data)); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr[15:11] != 5'b11010 || wr_addr[1:0] != 2'd0) |=>
            ($stable(size_q) && $stable(top_prog_q) && $stable(low_rom_q))); // R3

endmodule

// File: rtl/prg_map_calc.sv
module prg_map_calc
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0]   bank_q,
    input  size_mode_e                        size_q,
    input  logic                              top_prog_q,
    input  logic [BANK_W-1:0]                 and_mask,
    input  logic [BANK_W-1:0]                 or_offset,
    output logic [NUM_SLOTS-1:0][BANK_W-1:0]  slot_bank,
    output logic [1:0]                        slot_size,
    output logic [BANK_W-1:0]                 low_bank
);

    logic [REG_W-1:0]  top_val;
    logic [BANK_W-1:0] mask_w, ofs_w, mask_h, ofs_h;
    logic [REG_W-1:0]  low_raw;

    assign top_val = top_prog_q ? bank_q[NUM_SLOTS-1] : {REG_W{1'b1}};
    assign mask_w  = and_mask  >> 2;
    assign ofs_w   = or_offset >> 2;
    assign mask_h  = and_mask  >> 1;
    assign ofs_h   = or_offset >> 1;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            logic [REG_W-1:0] raw;
            logic [REG_W-1:0] half_src;
            assign raw      = (s == NUM_SLOTS-1) ? top_val : bank_q[s];
            assign half_src = (s < NUM_SLOTS/2)  ? bank_q[1] : top_val;
            always_comb begin
                unique case (size_q)
                    MODE_WIDE:    slot_bank[s] = (BANK_W'(top_val)  & mask_w) | ofs_w;
                    MODE_HALF:    slot_bank[s] = (BANK_W'(half_src) & mask_h) | ofs_h;
                    MODE_QUARTER: slot_bank[s] = (BANK_W'(raw) & and_mask) | or_offset;
                    default:      slot_bank[s] = (BANK_W'(mirror7(raw)) & and_mask) | or_offset;
                endcase
            end
        end
    endgenerate

    always_comb begin
        unique case (size_q)
            MODE_WIDE: begin
                low_raw   = {bank_q[3][REG_W-3:0], 2'b11};
                slot_size = WSZ_32K;
            end
            MODE_HALF: begin
                low_raw   = {bank_q[3][REG_W-2:0], 1'b1};
                slot_size = WSZ_16K;
            end
            MODE_QUARTER: begin
                low_raw   = bank_q[3];
                slot_size = WSZ_8K;
            end
            default: begin
                low_raw   = mirror7(bank_q[3]);
                slot_size = WSZ_8K;
            end
        endcase
    end

    assign low_bank = (BANK_W'(low_raw) & and_mask) | or_offset;

    AST_WIDE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == MODE_WIDE) |->
            (slot_bank[0] == slot_bank[1] && slot_bank[1] == slot_bank[2]
             && slot_bank[2] == slot_bank[3])); // R4

    AST_HALF_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == MODE_HALF) |->
            (slot_bank[0] == slot_bank[1] && slot_bank[2] == slot_bank[3])); // R5

    AST_LOW_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q != MODE_QUARTER && size_q != MODE_QUARTER_REV && and_mask[0] && !or_offset[0])
            |-> low_bank[0]); // R9

endmodule

// File: rtl/prg_map.sv
module prg_map
    import prg_map_pkg::*;
#(
    parameter int BANK_W      = 9,
    parameter bit RAM_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [BANK_W-1:0] and_mask,
    input  logic [BANK_W-1:0] or_offset,
    input  logic [15:0]       cpu_addr,
    output logic [BANK_W-1:0] rom_bank,
    output logic [1:0]        win_size,
    output logic              rom_sel,
    output logic              ram_sel
);

    logic [NUM_SLOTS-1:0][REG_W-1:0]  bank_q;
    size_mode_e                       size_q;
    logic                             top_prog_q;
    logic                             low_rom_q;
    logic [NUM_SLOTS-1:0][BANK_W-1:0] slot_bank;
    logic [1:0]                       slot_size;
    logic [BANK_W-1:0]                low_bank;

    prg_map_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .bank_q     (bank_q),
        .size_q     (size_q),
        .top_prog_q (top_prog_q),
        .low_rom_q  (low_rom_q)
    );

    prg_map_calc #(.BANK_W(BANK_W)) u_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_q     (bank_q),
        .size_q     (size_q),
        .top_prog_q (top_prog_q),
        .and_mask   (and_mask),
        .or_offset  (or_offset),
        .slot_bank  (slot_bank),
        .slot_size  (slot_size),
        .low_bank   (low_bank)
    );

    always_comb begin
        rom_bank = '0;
        win_size = WSZ_32K;
        rom_sel  = 1'b0;
        ram_sel  = 1'b0;
        if (cpu_addr[15]) begin
            rom_bank = slot_bank[cpu_addr[14:13]];
            win_size = slot_size;
            rom_sel  = 1'b1;
        end else if (cpu_addr[15:13] == 3'b011) begin
            win_size = WSZ_8K;
            if (low_rom_q) begin
                rom_bank = low_bank;
                rom_sel  = 1'b1;
            end else begin
                ram_sel  = RAM_PRESENT;
            end
        end
    end

    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel)); // R10

    AST_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (RAM_PRESENT == 1'b0) |-> !ram_sel); // R10

    AST_LOW_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!rom_sel && !ram_sel && rom_bank == '0)); // R12

    AST_UPPER_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15] |-> (rom_sel && !ram_sel)); // R12

endmodule

// File: tb/prg_map_bench.sv
module prg_map_bench;

    localparam int BW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [BW-1:0] and_mask = 9'h03F;
    logic [BW-1:0] or_offset = '0;
    logic [15:0]   cpu_addr = '0;
    logic [BW-1:0] rom_bank, nr_bank;
    logic [1:0]    win_size, nr_size;
    logic          rom_sel, ram_sel, nr_rom, nr_ram;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prg_map #(.BANK_W(BW), .RAM_PRESENT(1'b1)) u_prg_map (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .and_mask(and_mask), .or_offset(or_offset), .cpu_addr(cpu_addr),
        .rom_bank(rom_bank), .win_size(win_size), .rom_sel(rom_sel), .ram_sel(ram_sel)
    );

    prg_map #(.BANK_W(BW), .RAM_PRESENT(1'b0)) u_prg_map_noram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .and_mask(and_mask), .or_offset(or_offset), .cpu_addr(cpu_addr),
        .rom_bank(nr_bank), .win_size(nr_size), .rom_sel(nr_rom), .ram_sel(nr_ram)
    );

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic look(input logic [15:0] a, input logic e_rom, input logic e_ram,
                        input logic [BW-1:0] e_bank, input logic [1:0] e_size, input string tag);
        cpu_addr = a;
        #1;
        checks++;
        if (rom_sel !== e_rom || ram_sel !== e_ram || rom_bank !== e_bank ||
            ((e_rom || e_ram) && win_size !== e_size)) begin
            errors++;
            $display("FAIL %s addr=%h: rom=%b ram=%b bank=%h size=%0d expected rom=%b ram=%b bank=%h size=%0d",
                     tag, a, rom_sel, ram_sel, rom_bank, win_size, e_rom, e_ram, e_bank, e_size);
        end
    endtask

    task automatic look_noram(input logic [15:0] a, input logic e_rom, input string tag);
        cpu_addr = a;
        #1;
        checks++;
        if (nr_ram !== 1'b0 || nr_rom !== e_rom) begin
            errors++;
            $display("FAIL %s addr=%h: noram rom=%b ram=%b expected rom=%b ram=0",
                     tag, a, nr_rom, nr_ram, e_rom);
        end
    endtask

    task automatic t_reset;
        look(16'h8000, 1, 0, 9'h00F, 2'd0, "R1 wide after reset");
        look(16'hF123, 1, 0, 9'h00F, 2'd0, "R1 R8 pinned top");
        look(16'h6000, 0, 1, 9'h000, 2'd2, "R1 R10 ram at 6000");
        look_noram(16'h7FFF, 0, "R10 no ram fitted");
        look(16'h5FFF, 0, 0, 9'h000, 2'd0, "R12 below window");
        look(16'h0000, 0, 0, 9'h000, 2'd0, "R12 zero page");
    endtask

    task automatic t_regs;
        cpu_write(16'h8000, 8'h05);
        cpu_write(16'h8001, 8'h12);
        cpu_write(16'h8002, 8'h27);
        cpu_write(16'h87FF, 8'h39);
        cpu_write(16'hD000, 8'h02);
        look(16'h8000, 1, 0, 9'h005, 2'd2, "R2 R6 slot0");
        look(16'hA000, 1, 0, 9'h012, 2'd2, "R6 slot1");
        look(16'hC000, 1, 0, 9'h027, 2'd2, "R6 slot2");
        look(16'hE000, 1, 0, 9'h03F, 2'd2, "R6 R8 pinned slot3");
        cpu_write(16'h8800, 8'h77);
        cpu_write(16'h8FFF, 8'h77);
        look(16'h8000, 1, 0, 9'h005, 2'd2, "R2 8800 ignored");
        cpu_write(16'hD001, 8'h00);
        cpu_write(16'hD800, 8'h00);
        look(16'hA000, 1, 0, 9'h012, 2'd2, "R3 other mode writes ignored");
    endtask

    task automatic t_top_and_low;
        cpu_write(16'hD000, 8'h06);
        look(16'hE000, 1, 0, 9'h039, 2'd2, "R8 programmable top");
        cpu_write(16'hD000, 8'h86);
        look(16'h6000, 1, 0, 9'h039, 2'd2, "R9 R3 quarter low rom");
        look_noram(16'h6000, 1, "R10 rom wins with no ram");
    endtask

    task automatic t_wide_half;
        cpu_write(16'hD000, 8'h84);
        look(16'h8000, 1, 0, 9'h009, 2'd0, "R4 wide");
        look(16'hE000, 1, 0, 9'h009, 2'd0, "R4 wide top");
        look(16'h6000, 1, 0, 9'h027, 2'd2, "R9 wide low bank");
        cpu_write(16'hD000, 8'h85);
        look(16'h8000, 1, 0, 9'h012, 2'd1, "R5 half low");
        look(16'hBFFF, 1, 0, 9'h012, 2'd1, "R5 half low end");
        look(16'hC000, 1, 0, 9'h019, 2'd1, "R5 half high");
        look(16'h6000, 1, 0, 9'h033, 2'd2, "R9 half low bank");
        cpu_write(16'hD000, 8'h81);
        look(16'hC000, 1, 0, 9'h01F, 2'd1, "R5 R8 half pinned");
    endtask

    task automatic t_reverse;
        cpu_write(16'hD000, 8'h87);
        look(16'h8000, 1, 0, 9'h010, 2'd2, "R7 rev slot0");
        look(16'hA000, 1, 0, 9'h024, 2'd2, "R7 rev slot1");
        look(16'hC000, 1, 0, 9'h032, 2'd2, "R7 rev slot2");
        look(16'hE000, 1, 0, 9'h00E, 2'd2, "R7 rev slot3");
        look(16'h6000, 1, 0, 9'h00E, 2'd2, "R7 R9 rev low bank");
        and_mask = 9'h1FF;
        cpu_write(16'hD000, 8'h03);
        look(16'hE000, 1, 0, 9'h07F, 2'd2, "R7 rev pinned bit7 cleared");
        look(16'h6000, 0, 1, 9'h000, 2'd2, "R10 ram back at 6000");
    endtask

    task automatic t_mask;
        and_mask = 9'h00F; or_offset = 9'h140;
        cpu_write(16'hD000, 8'h02);
        look(16'h8000, 1, 0, 9'h145, 2'd2, "R11 quarter outer");
        look(16'hA000, 1, 0, 9'h142, 2'd2, "R11 quarter outer slot1");
        cpu_write(16'hD000, 8'h00);
        look(16'h9000, 1, 0, 9'h053, 2'd0, "R11 R4 wide outer");
        cpu_write(16'hD000, 8'h01);
        look(16'h8000, 1, 0, 9'h0A2, 2'd1, "R11 R5 half outer low");
        look(16'hC000, 1, 0, 9'h0A7, 2'd1, "R11 R5 half outer high");
        cpu_write(16'hD000, 8'h81);
        look(16'h6000, 1, 0, 9'h143, 2'd2, "R11 R9 outer low bank");
        look(16'h4000, 0, 0, 9'h000, 2'd0, "R12 outer no select");
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_top_and_low();
        t_wide_half();
        t_reverse();
        t_mask();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule